// File: doc/BRIEF.md
# Integer Execution Unit for a Randomized-Program VM

This block computes the 64-bit integer result of one instruction of a virtual machine whose programs are random bit strings. Each issue presents the primary operand A, the value of a source register, a 32-bit and an 8-bit immediate, a 2-bit source-location field and a 5-bit operation code. The unit picks the second operand B from those inputs according to the operation's class, applies one of 22 integer operations and returns the result C.

Every operation takes the same fixed path: the result is registered and appears one clock after issue, flagged by `valid_out`, so results always leave in issue order. Since any bit pattern must stay legal, division never traps. A zero divisor or a signed overflow gives back the dividend. Codes with no operation assigned pass A through unchanged.

Top module: `iexu_top`

## Requirements
- R1: A cycle with `valid_in` high gives `valid_out` high on the next cycle, with that issue's result on `c_out`. A cycle with `valid_in` low gives `valid_out` low on the next cycle and leaves `c_out` unchanged. Back-to-back issues come out in issue order.
- R2: The source of B depends on the class and on `loc_b`. Division (codes 9, 10) takes the register when `loc_b`=0 and the 32-bit immediate otherwise. Shift/rotate (codes 17–21) takes the register for `loc_b`=0,1 and the zero-extended 8-bit immediate for 2,3. All other codes take the register for 0–2 and the 32-bit immediate for 3.
- R3: When B comes from the 32-bit immediate, the immediate is sign-extended to 64 bits.
- R4: ADD32 (1), SUB32 (3), AND32 (12), OR32 (14) and XOR32 (16) use only bits 31:0 of A and B. They force C[63:32] to zero. ADD64 (0), SUB64 (2), AND64 (11), OR64 (13) and XOR64 (15) work on the full 64 bits.
- R5: MUL64 (4) gives the low 64 bits of the unsigned 128-bit product. MULHU (5) gives its high 64 bits. MULHS (8) gives the high 64 bits of the signed product.
- R6: MUL32 (6) and IMUL32 (7) multiply A[31:0] by B[31:0] to a full 64-bit product. MUL32 is unsigned and IMUL32 is two's complement. A[63:32] and B[63:32] have no effect.
- R7: DIVU (9) divides the unsigned 64-bit A by the unsigned B[31:0]. DIVS (10) divides the signed A by the signed B[31:0], with the quotient truncated toward zero. B[63:32] has no effect.
- R8: If B[31:0] is zero, either division returns A. DIVS also returns A when A = 0x8000000000000000 and B[31:0] = 0xFFFFFFFF. DIVU treats that same pair as an ordinary division.
- R9: SHL (17), SHR (18), SAR (19), ROL (20) and ROR (21) use only B[5:0] as the count. SAR replicates bit 63. The other four treat A as unsigned.
- R10: Codes 22 to 31 return C = A.
- R11: During reset `valid_out` and `c_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Issue strobe |
| op_sel | input | 5 | Operation code |
| loc_b | input | 2 | Operand-B location field |
| a_in | input | 64 | Operand A |
| reg_b | input | 64 | Source register value |
| imm32 | input | 32 | 32-bit immediate |
| imm8 | input | 8 | 8-bit immediate |
| valid_out | output | 1 | Result valid |
| c_out | output | 64 | Result C |

## Verification
The signed-overflow guard on division is the hardest case to reach. It needs exactly the most negative dividend together with a divisor whose low 32 bits are all ones. The bench builds this pair on purpose. It sends the same pair through the unsigned divide, which must return a genuine quotient, and it puts nonzero upper bits on the register B to show that only the low half counts as the divisor. Immediate selection gets the same treatment: the register and the immediates carry conflicting values, so a wrong pick shows up as a different result.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  localparam int XLEN = 64;
  localparam int HLEN = XLEN / 2;
  localparam int OPW  = 5;
  localparam int SHW  = $clog2(XLEN);
  localparam int I8W  = 8;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 5'd0,  OP_ADDW  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBW  = 5'd3,
    OP_MUL   = 5'd4,  OP_MULHU = 5'd5,  OP_MULW  = 5'd6,  OP_MULWS = 5'd7,
    OP_MULHS = 5'd8,  OP_DIVU  = 5'd9,  OP_DIVS  = 5'd10, OP_AND   = 5'd11,
    OP_ANDW  = 5'd12, OP_OR    = 5'd13, OP_ORW   = 5'd14, OP_XOR   = 5'd15,
    OP_XORW  = 5'd16, OP_SLL   = 5'd17, OP_SRL   = 5'd18, OP_SRA   = 5'd19,
    OP_ROTL  = 5'd20, OP_ROTR  = 5'd21
  } op_e;

  typedef enum logic [1:0] {CLS_MATH, CLS_DIV, CLS_SHIFT} cls_e;
  typedef enum logic [1:0] {BSRC_REG, BSRC_IMM32, BSRC_IMM8} bsrc_e;

  function automatic cls_e class_of(input logic [OPW-1:0] op);
    if (op == OP_DIVU || op == OP_DIVS) return CLS_DIV;
    if (op >= OP_SLL && op <= OP_ROTR)  return CLS_SHIFT;
    return CLS_MATH;
  endfunction

  function automatic logic is_narrow(input logic [OPW-1:0] op);
    return (op == OP_ADDW) || (op == OP_SUBW) || (op == OP_ANDW) ||
           (op == OP_ORW)  || (op == OP_XORW);
  endfunction

  function automatic logic [XLEN-1:0] zext_half(input logic [HLEN-1:0] v);
    return {{(XLEN-HLEN){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] mul_hi_u(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [2*XLEN-1:0] p;
    p = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
    return p[2*XLEN-1:XLEN];
  endfunction

  function automatic logic [XLEN-1:0] mul_hi_s(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [2*XLEN-1:0] p;
    p = $signed({{XLEN{a[XLEN-1]}}, a}) * $signed({{XLEN{b[XLEN-1]}}, b});
    return p[2*XLEN-1:XLEN];
  endfunction

  function automatic logic [XLEN-1:0] mul_half_u(input logic [HLEN-1:0] a,
                                                 input logic [HLEN-1:0] b);
    return zext_half(a) * zext_half(b);
  endfunction

  function automatic logic [XLEN-1:0] mul_half_s(input logic [HLEN-1:0] a,
                                                 input logic [HLEN-1:0] b);
    return $signed({{(XLEN-HLEN){a[HLEN-1]}}, a}) *
           $signed({{(XLEN-HLEN){b[HLEN-1]}}, b});
  endfunction
endpackage

// File: rtl/iexu_opb_sel.sv
module iexu_opb_sel
  import iexu_pkg::*;
#(
  parameter int XW = XLEN,
  parameter int HW = HLEN,
  parameter int IW = I8W
) (
  input  cls_e            cls,
  input  logic [1:0]      loc,
  input  logic [XW-1:0]   reg_val,
  input  logic [HW-1:0]   imm_w,
  input  logic [IW-1:0]   imm_b,
  output bsrc_e           src,
  output logic [XW-1:0]   b_val
);
  always_comb begin
    unique case (cls)
      CLS_DIV:   src = (loc == 2'd0) ? BSRC_REG : BSRC_IMM32;
      CLS_SHIFT: src = loc[1] ? BSRC_IMM8 : BSRC_REG;
      default:   src = (loc == 2'd3) ? BSRC_IMM32 : BSRC_REG;
    endcase
  end

  always_comb begin
    unique case (src)
      BSRC_IMM32: b_val = {{(XW-HW){imm_w[HW-1]}}, imm_w};
      BSRC_IMM8:  b_val = {{(XW-IW){1'b0}}, imm_b};
      default:    b_val = reg_val;
    endcase
  end
endmodule

// File: rtl/iexu_math.sv
module iexu_math
  import iexu_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  logic [HLEN-1:0] a_lo, b_lo;
  assign a_lo = a[HLEN-1:0];
  assign b_lo = b[HLEN-1:0];

  always_comb begin
    unique case (op)
      OP_ADD:   res = a + b;
      OP_ADDW:  res = zext_half(a_lo + b_lo);
      OP_SUB:   res = a - b;
      OP_SUBW:  res = zext_half(a_lo - b_lo);
      OP_MUL:   res = a * b;
      OP_MULHU: res = mul_hi_u(a, b);
      OP_MULW:  res = mul_half_u(a_lo, b_lo);
      OP_MULWS: res = mul_half_s(a_lo, b_lo);
      OP_MULHS: res = mul_hi_s(a, b);
      OP_AND:   res = a & b;
      OP_ANDW:  res = zext_half(a_lo & b_lo);
      OP_OR:    res = a | b;
      OP_ORW:   res = zext_half(a_lo | b_lo);
      OP_XOR:   res = a ^ b;
      OP_XORW:  res = zext_half(a_lo ^ b_lo);
      default:  res = a;
    endcase
  end
endmodule

// File: rtl/iexu_shift.sv
module iexu_shift
  import iexu_pkg::*;
#(
  parameter int XW = XLEN,
  parameter int SW = SHW
) (
  input  logic [OPW-1:0] op,
  input  logic [XW-1:0]  a,
  input  logic [SW-1:0]  cnt,
  output logic [XW-1:0]  res
);
  logic [2*XW-1:0] dbl_l, dbl_r;
  assign dbl_l = {a, a} << cnt;
  assign dbl_r = {a, a} >> cnt;

  always_comb begin
    unique case (op)
      OP_SLL:  res = a << cnt;
      OP_SRL:  res = a >> cnt;
      OP_SRA:  res = XW'($signed(a) >>> cnt);
      OP_ROTL: res = dbl_l[2*XW-1:XW];
      OP_ROTR: res = dbl_r[XW-1:0];
      default: res = a;
    endcase
  end
endmodule

// File: rtl/iexu_div.sv
module iexu_div #(
  parameter int XW = 64,
  parameter int HW = 32
) (
  input  logic          is_signed,
  input  logic [XW-1:0] a,
  input  logic [HW-1:0] d,
  output logic [XW-1:0] q,
  output logic          by_zero,
  output logic          sgn_ovf
);
  localparam logic [XW-1:0] MOST_NEG = {1'b1, {(XW-1){1'b0}}};

  assign by_zero = (d == '0);
  assign sgn_ovf = is_signed && (a == MOST_NEG) && (d == '1);

  always_comb begin
    if (by_zero || sgn_ovf)
      q = a;
    else if (is_signed)
      q = XW'($signed(a) / $signed({{(XW-HW){d[HW-1]}}, d}));
    else
      q = a / {{(XW-HW){1'b0}}, d};
  end
endmodule

// File: rtl/iexu_top.sv
module iexu_top
  import iexu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [OPW-1:0]   op_sel,
  input  logic [1:0]       loc_b,
  input  logic [XLEN-1:0]  a_in,
  input  logic [XLEN-1:0]  reg_b,
  input  logic [HLEN-1:0]  imm32,
  input  logic [I8W-1:0]   imm8,
  output logic             valid_out,
  output logic [XLEN-1:0]  c_out
);
  cls_e            op_cls;
  bsrc_e           b_src;
  logic [XLEN-1:0] b_val;
  logic [XLEN-1:0] math_res, shift_res, div_res, next_c;
  logic            div_zero, div_ovf;

  assign op_cls = class_of(op_sel);

  iexu_opb_sel #(.XW(XLEN), .HW(HLEN), .IW(I8W)) i_opb (
    .cls(op_cls), .loc(loc_b), .reg_val(reg_b), .imm_w(imm32), .imm_b(imm8),
    .src(b_src), .b_val(b_val)
  );

  iexu_math i_math (.op(op_sel), .a(a_in), .b(b_val), .res(math_res));

  iexu_shift #(.XW(XLEN), .SW(SHW)) i_shift (
    .op(op_sel), .a(a_in), .cnt(b_val[SHW-1:0]), .res(shift_res)
  );

  iexu_div #(.XW(XLEN), .HW(HLEN)) i_div (
    .is_signed(op_sel == OP_DIVS), .a(a_in), .d(b_val[HLEN-1:0]),
    .q(div_res), .by_zero(div_zero), .sgn_ovf(div_ovf)
  );

  always_comb begin
    unique case (op_cls)
      CLS_DIV:   next_c = div_res;
      CLS_SHIFT: next_c = shift_res;
      default:   next_c = math_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      c_out     <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) c_out <= next_c;
    end
  end
endmodule

// File: rtl/iexu_chk.sv
module iexu_chk
  import iexu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            valid_in,
  input logic [OPW-1:0]  op_sel,
  input logic [1:0]      loc_b,
  input logic [XLEN-1:0] a_in,
  input logic            valid_out,
  input logic [XLEN-1:0] c_out,
  input bsrc_e           b_src,
  input logic            div_zero,
  input logic            div_ovf
);
  logic is_div;
  assign is_div = (op_sel == OP_DIVU) || (op_sel == OP_DIVS);

  // R1
  a_r1_issue_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(c_out));
  // R2
  a_r2_shift_imm8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op_sel >= OP_SLL && op_sel <= OP_ROTR && loc_b[1]) |-> b_src == BSRC_IMM8);
  a_r2_div_imm32: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && is_div && loc_b != 2'd0) |-> b_src == BSRC_IMM32);
  // R4
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && is_narrow(op_sel)) |=> c_out[XLEN-1:HLEN] == '0);
  // R8
  a_r8_div_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && is_div && (div_zero || div_ovf)) |=> c_out == $past(a_in));
  // R10
  a_r10_unused_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op_sel > OP_ROTR) |=> c_out == $past(a_in));
endmodule

bind iexu_top iexu_chk i_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_sel(op_sel), .loc_b(loc_b),
  .a_in(a_in), .valid_out(valid_out), .c_out(c_out), .b_src(b_src),
  .div_zero(div_zero), .div_ovf(div_ovf)
);

// File: tb/test_iexu_top.sv
`timescale 1ns/1ps
module test_iexu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [1:0]  loc_b = '0;
  logic [63:0] a_in = '0, reg_b = '0;
  logic [31:0] imm32 = '0;
  logic [7:0]  imm8 = '0;
  logic        valid_out;
  logic [63:0] c_out;
  int checks = 0;
  int errors = 0;

  localparam logic [4:0] ADD=0, ADDW=1, SUB=2, SUBW=3, MUL=4, MULHU=5, MULW=6,
    MULWS=7, MULHS=8, DIVU=9, DIVS=10, XORW=16, SHL=17, SHR=18, SAR=19, ROL=20, ROR=21;

  always #2.5 clk = ~clk;

  iexu_top i_iexu_top (.*);

  task automatic check64(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic drive(input logic [4:0] op, input logic [1:0] loc, input logic [63:0] a,
                       input logic [63:0] rb, input logic [31:0] i32, input logic [7:0] i8);
    op_sel = op; loc_b = loc; a_in = a; reg_b = rb; imm32 = i32; imm8 = i8; valid_in = 1'b1;
  endtask

  task automatic run_op(input logic [4:0] op, input logic [1:0] loc, input logic [63:0] a,
                        input logic [63:0] rb, input logic [31:0] i32, input logic [7:0] i8,
                        input logic [63:0] exp, input string tag);
    @(negedge clk);
    drive(op, loc, a, rb, i32, i8);
    @(negedge clk);
    valid_in = 1'b0;
    check64({63'd0, valid_out}, 64'd1, {tag, " valid"});
    check64(c_out, exp, tag);
  endtask

  task automatic t_reset();
    check64({63'd0, valid_out}, 64'd0, "R11 valid_out in reset");
    check64(c_out, 64'd0, "R11 c_out in reset");
  endtask

  task automatic t_pipeline();
    logic [63:0] held;
    @(negedge clk);
    drive(ADD, 2'd0, 64'd5, 64'd7, 32'd0, 8'd0);
    @(negedge clk);
    drive(SUB, 2'd0, 64'd0, 64'd1, 32'd0, 8'd0);
    check64(c_out, 64'd12, "R1 first of pair");
    @(negedge clk);
    valid_in = 1'b0;
    a_in = 64'h55;
    check64(c_out, 64'hFFFF_FFFF_FFFF_FFFF, "R1 second of pair");
    held = c_out;
    @(negedge clk);
    check64({63'd0, valid_out}, 64'd0, "R1 idle valid_out");
    check64(c_out, held, "R1 idle holds c_out");
  endtask

  task automatic t_bsel();
    run_op(ADD, 2'd1, 64'd1, 64'd3, 32'd1000, 8'd0, 64'd4, "R2 math loc1 register");
    run_op(ADD, 2'd2, 64'd1, 64'd3, 32'd1000, 8'd0, 64'd4, "R2 math loc2 register");
    run_op(ADD, 2'd3, 64'd10, 64'd3, 32'hFFFF_FFFF, 8'd0, 64'd9, "R2 R3 math loc3 imm32 sext");
    run_op(DIVU, 2'd1, 64'h2_0000_0000, 64'd1, 32'hFFFF_FFFF, 8'd0, 64'd2, "R2 div loc1 imm32");
    run_op(SHL, 2'd2, 64'd1, 64'd63, 32'd0, 8'hC4, 64'd16, "R2 R9 shift loc2 imm8");
    run_op(SHL, 2'd1, 64'd1, 64'h41, 32'd0, 8'd9, 64'd2, "R2 R9 shift loc1 register, count bits 5:0");
  endtask

  task automatic t_narrow();
    run_op(ADDW, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 8'd0, 64'd0, "R4 ADD32 wrap");
    run_op(SUBW, 2'd0, 64'h1_0000_0000, 64'd1, 32'd0, 8'd0, 64'h0000_0000_FFFF_FFFF, "R4 SUB32");
    run_op(XORW, 2'd0, 64'hAAAA_AAAA_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 8'd0,
           64'h0000_0000_EDCB_A987, "R4 XOR32");
  endtask

  task automatic t_mul();
    run_op(MUL, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 32'd0, 8'd0, 64'hFFFF_FFFF_FFFF_FFFE, "R5 MUL64 low");
    run_op(MULHU, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 32'd0, 8'd0, 64'd1, "R5 MULHU high");
    run_op(MULHS, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 32'd0, 8'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R5 MULHS high");
    run_op(MULW, 2'd0, 64'h1234_5678_FFFF_FFFF, 64'h9999_0000_FFFF_FFFF, 32'd0, 8'd0,
           64'hFFFF_FFFE_0000_0001, "R6 MUL32 unsigned");
    run_op(MULWS, 2'd0, 64'h1234_5678_FFFF_FFFF, 64'h9999_0000_FFFF_FFFF, 32'd0, 8'd0,
           64'd1, "R6 IMUL32 signed");
  endtask

  task automatic t_div();
    run_op(DIVU, 2'd0, 64'd100, 64'h1_0000_0007, 32'd0, 8'd0, 64'd14, "R7 DIVU low-half divisor");
    run_op(DIVS, 2'd0, 64'hFFFF_FFFF_FFFF_FFF9, 64'h0000_0000_FFFF_FFFE, 32'd0, 8'd0, 64'd3, "R7 DIVS neg/neg");
    run_op(DIVS, 2'd0, 64'd7, 64'h0000_0000_FFFF_FFFE, 32'd0, 8'd0, 64'hFFFF_FFFF_FFFF_FFFD, "R7 DIVS truncation");
    run_op(DIVU, 2'd0, 64'h1234, 64'hABCD_0000_0000, 32'd0, 8'd0, 64'h1234, "R8 DIVU by zero");
    run_op(DIVS, 2'd0, 64'h8000_0000_0000_0000, 64'h7777_0000_FFFF_FFFF, 32'd0, 8'd0,
           64'h8000_0000_0000_0000, "R8 DIVS overflow");
    run_op(DIVU, 2'd0, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF, 32'd0, 8'd0,
           64'h0000_0000_8000_0000, "R8 DIVU same pair divides");
  endtask

  task automatic t_shift();
    run_op(SAR, 2'd3, 64'h8000_0000_0000_0000, 64'd0, 32'd0, 8'h3F, 64'hFFFF_FFFF_FFFF_FFFF, "R9 SAR sign fill");
    run_op(SHR, 2'd3, 64'h8000_0000_0000_0000, 64'd0, 32'd0, 8'h3F, 64'd1, "R9 SHR zero fill");
    run_op(ROL, 2'd0, 64'h8000_0000_0000_0001, 64'd1, 32'd0, 8'd0, 64'd3, "R9 ROL");
    run_op(ROR, 2'd0, 64'd1, 64'd4, 32'd0, 8'd0, 64'h1000_0000_0000_0000, "R9 ROR");
  endtask

  task automatic t_unused();
    run_op(5'd25, 2'd3, 64'hDEAD_BEEF, 64'd1, 32'd7, 8'd3, 64'hDEAD_BEEF, "R10 unused code");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pipeline();
    t_bsel();
    t_narrow();
    t_mul();
    t_div();
    t_shift();
    t_unused();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule